// File: doc/BRIEF.md
# Cascadable Serial-In Parallel-Out Output Driver Core

This block is the logic core of a channel driver that takes a single serial bit stream and turns it into a wide vector of sink-enable controls. Each bit of `drv_on` is 1 when the matching open-drain sink should conduct. Bits enter a shift register on every falling edge of `clk`. On a rising edge with `xfer` high, the register contents move into a bank of holding latches. Two shared controls, `pass` and `sense`, then decide whether the outputs show the latch bits, show them inverted, or are all forced on or all forced off.

The last register stage is brought out on `sdo`. The `sdo` of one instance feeds the `sdi` of the next, so several instances behave as one longer register. A controller shifts in one bit per channel for the whole chain, raises `xfer` once, and then sets the drive mode for all channels at the same time.

Top module: `serpar_drv`

## Requirements
- R1: On each falling edge of `clk` with `rst` low, stage 0 of the shift register takes `sdi` and stage k takes the old value of stage k-1. A 1 shifted into a cleared register reaches `sdo` after exactly WIDTH falling edges.
- R2: `sdo` always equals the last shift stage (bit WIDTH-1), so it changes only after falling edges.
- R3: The shift path behaves the same whatever the values of `xfer`, `pass` and `sense`.
- R4: On a rising edge with `xfer` high, the latches take the current shift-register contents. While `xfer` stays high they keep following it on each rising edge. With `xfer` low they hold.
- R5: With `pass` low and `sense` low, every bit of `drv_on` becomes 1 at the next rising edge.
- R6: With `pass` low and `sense` high, every bit of `drv_on` becomes 0 at the next rising edge.
- R7: With `pass` high and `sense` high, `drv_on[i]` equals latch bit i. Latch bit i drives channel i+1.
- R8: With `pass` high and `sense` low, `drv_on[i]` is the inverse of latch bit i.
- R9: `drv_on` is registered on the rising edge. When `xfer` is high at that edge, it already reflects the newly loaded latch value under the mode sampled at the same edge.
- R10: `rst` is synchronous and active high. It clears the shift register on a falling edge, and clears the latches and `drv_on` on a rising edge.
- R11: When two instances are chained, 2*WIDTH shifted bits followed by one transfer place the first bit sent in the far device's last stage. After that transfer the combined vector {far, near} equals the sent word, taking the first bit sent as the MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; shifting on falling edge, transfer and output on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data in |
| xfer | input | 1 | High: latches load from the shift register; low: latches hold |
| pass | input | 1 | High: latch data reaches outputs; low: outputs forced |
| sense | input | 1 | Polarity select for the forced level and for direct or inverted pass |
| sdo | output | 1 | Serial data out (last shift stage), for chaining |
| drv_on | output | WIDTH | Sink-enable per channel, bit i = channel i+1 |

## Verification
A latch transfer and a change of drive mode can land on the same rising edge. The output register then has to combine the freshly loaded latch value with the newly selected mode, with no stale mix of either. The bench provokes this by raising `xfer` in the same step that it switches `sense`, after walking a single 1 through a cleared chain. The resulting vector is compared against a behavioural model that applies the transfer first and the mode second. A second overlap checked on every clock is shifting while `xfer` is held high: the latches must track each new shift, one rising edge after the falling edge that moved it.

// File: rtl/serpar_pkg.sv
package serpar_pkg;

  // Drive mode selected by the pass/sense pair.
  typedef enum logic [1:0] {
    MODE_ALL_ON  = 2'd0,
    MODE_ALL_OFF = 2'd1,
    MODE_INVERT  = 2'd2,
    MODE_FOLLOW  = 2'd3
  } drv_mode_e;

  function automatic drv_mode_e mode_of(input logic pass, input logic sense);
    drv_mode_e m;
    case ({pass, sense})
      2'b00:   m = MODE_ALL_ON;
      2'b01:   m = MODE_ALL_OFF;
      2'b10:   m = MODE_INVERT;
      default: m = MODE_FOLLOW;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/serpar_shift.sv
module serpar_shift #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdi,
  output logic [WIDTH-1:0] sr_q
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] sr_d;

  // Next-state per stage: stage 0 from the serial pin, others from their neighbour.
  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign sr_d[k] = sdi;
    end else begin : g_body
      assign sr_d[k] = sr_q[k-1];
    end
  end

  // Falling-edge shift, independent of every other control.
  always_ff @(negedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= sr_d;
  end

  logic unused_last;
  assign unused_last = sr_d[LAST];

endmodule

// File: rtl/serpar_latch.sv
module serpar_latch #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer,
  input  logic [WIDTH-1:0] sr_in,
  output logic [WIDTH-1:0] lat_nxt,
  output logic [WIDTH-1:0] lat_q
);
  // Sampled equivalent of a level-sensitive latch bank.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign lat_nxt[i] = xfer ? sr_in[i] : lat_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else     lat_q <= lat_nxt;
  end

endmodule

// File: rtl/serpar_gate.sv
module serpar_gate
  import serpar_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pass,
  input  logic             sense,
  input  logic [WIDTH-1:0] lat_in,
  output logic [WIDTH-1:0] drv_on
);
  drv_mode_e        mode;
  logic [WIDTH-1:0] on_d;
  logic             f_on, f_inv, f_fol;

  assign mode  = mode_of(pass, sense);
  assign f_on  = (mode == MODE_ALL_ON);
  assign f_inv = (mode == MODE_INVERT);
  assign f_fol = (mode == MODE_FOLLOW);

  for (genvar i = 0; i < WIDTH; i++) begin : g_ch
    assign on_d[i] = f_on | (f_fol & lat_in[i]) | (f_inv & ~lat_in[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) drv_on <= '0;
    else     drv_on <= on_d;
  end

endmodule

// File: rtl/serpar_drv.sv
module serpar_drv #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdi,
  input  logic             xfer,
  input  logic             pass,
  input  logic             sense,
  output logic             sdo,
  output logic [WIDTH-1:0] drv_on
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] lat_nxt;

  serpar_shift #(.WIDTH(WIDTH)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .sdi  (sdi),
    .sr_q (sr_q)
  );

  assign sdo = sr_q[LAST];

  serpar_latch #(.WIDTH(WIDTH)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .xfer    (xfer),
    .sr_in   (sr_q),
    .lat_nxt (lat_nxt),
    .lat_q   (lat_q)
  );

  serpar_gate #(.WIDTH(WIDTH)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .pass   (pass),
    .sense  (sense),
    .lat_in (lat_nxt),
    .drv_on (drv_on)
  );

endmodule

// File: rtl/serpar_drv_chk.sv
module serpar_drv_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             sdi,
  input logic             xfer,
  input logic             pass,
  input logic             sense,
  input logic             sdo,
  input logic [WIDTH-1:0] sr_q,
  input logic [WIDTH-1:0] lat_q,
  input logic [WIDTH-1:0] drv_on
);
  localparam int LAST = WIDTH - 1;

  a_r1_head: assert property (@(negedge clk) disable iff (rst)
    1'b1 |=> (sr_q[0] == $past(sdi)));

  a_r1_advance: assert property (@(negedge clk) disable iff (rst)
    1'b1 |=> (sr_q[LAST:1] == $past(sr_q[LAST-1:0])));

  a_r2_cascade: assert property (@(negedge clk) disable iff (rst)
    1'b1 |=> (sdo == $past(sr_q[LAST-1])));

  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (lat_q == $past(sr_q)));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(lat_q));

  a_r5_all_on: assert property (@(posedge clk) disable iff (rst)
    (!pass && !sense) |=> (drv_on == {WIDTH{1'b1}}));

  a_r6_all_off: assert property (@(posedge clk) disable iff (rst)
    (!pass && sense) |=> (drv_on == '0));

  a_r7_follow: assert property (@(posedge clk) disable iff (rst)
    (pass && sense && !xfer) |=> (drv_on == lat_q));

  a_r8_invert: assert property (@(posedge clk) disable iff (rst)
    (pass && !sense && !xfer) |=> (drv_on == ~lat_q));

endmodule

bind serpar_drv serpar_drv_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sdi    (sdi),
  .xfer   (xfer),
  .pass   (pass),
  .sense  (sense),
  .sdo    (sdo),
  .sr_q   (sr_q),
  .lat_q  (lat_q),
  .drv_on (drv_on)
);

// File: tb/serpar_drv_tb.sv
module serpar_drv_tb;
  localparam int W  = 32;
  localparam int W2 = 2 * W;
  localparam logic [W2-1:0] PAT = 64'hA5C3_0F96_1E2D_7B48;

  logic clk = 1'b0, rst = 1'b1, sdi = 1'b0, xfer = 1'b0, pass = 1'b1, sense = 1'b1;
  logic link, sdo_end;
  logic [W-1:0] drv0, drv1;

  int total = 0, bad = 0;
  bit done  = 1'b0;

  bit            q[$];
  logic [W2-1:0] mlat = '0, mdrv = '0;

  always #10 clk = ~clk;

  serpar_drv #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .sdi(sdi), .xfer(xfer), .pass(pass), .sense(sense),
    .sdo(link), .drv_on(drv0));

  serpar_drv #(.WIDTH(W)) u_nxt (
    .clk(clk), .rst(rst), .sdi(link), .xfer(xfer), .pass(pass), .sense(sense),
    .sdo(sdo_end), .drv_on(drv1));

  task automatic check(input string tag, input logic [W2-1:0] act, input logic [W2-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic model_shift();
    if (rst) begin
      foreach (q[k]) q[k] = 1'b0;
    end else begin
      q.push_front(sdi);
      void'(q.pop_back());
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      mlat = '0;
      mdrv = '0;
    end else begin
      if (xfer) for (int k = 0; k < W2; k++) mlat[k] = q[k];
      if (!pass) mdrv = sense ? '0 : '1;
      else       mdrv = sense ? mlat : ~mlat;
    end
  endtask

  // One clock: inputs change at rising+5, model follows both edges, compare at rising+5.
  task automatic step(input logic d, input logic l, input logic p, input logic s);
    sdi = d; xfer = l; pass = p; sense = s;
    @(negedge clk); model_shift();
    @(posedge clk); model_edge();
    #5;
    check("R2 near sdo vs model", link, q[W-1]);
    check("R11 far sdo vs model", sdo_end, q[W2-1]);
    check("R9 drive vector vs model", {drv1, drv0}, mdrv);
  endtask

  initial begin
    #3_000_000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    for (int k = 0; k < W2; k++) q.push_back(1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    rst = 1'b0;
    check("R10 drive cleared after reset", {drv1, drv0}, '0);
    check("R10 sdo cleared after reset", link, 1'b0);

    for (int j = 0; j < W2 - 1; j++) step(PAT[W2-1-j], 1'b0, 1'b1, 1'b1);
    check("R4 hold while xfer low", {drv1, drv0}, '0);
    step(PAT[0], 1'b1, 1'b1, 1'b1);
    check("R11 chained word after transfer", {drv1, drv0}, PAT);
    check("R11 first bit at far end", sdo_end, PAT[W2-1]);
    check("R1 near sdo after full chain", link, PAT[W-1]);

    step(1'b1, 1'b0, 1'b1, 1'b0);
    check("R8 invert mode", {drv1, drv0}, ~PAT);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 all forced on", {drv1, drv0}, {W2{1'b1}});
    step(1'b1, 1'b0, 1'b0, 1'b1);
    check("R6 all forced off", {drv1, drv0}, '0);
    check("R3 near shift unaffected by controls", link, PAT[28]);
    check("R3 far shift unaffected by controls", sdo_end, PAT[60]);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    check("R7 follow latch after hold", {drv1, drv0}, PAT);

    rst = 1'b1;
    step(1'b1, 1'b1, 1'b0, 1'b0);
    rst = 1'b0;
    check("R10 mid-run reset clears drive", {drv1, drv0}, '0);
    check("R10 mid-run reset clears sdo", link, 1'b0);

    step(1'b1, 1'b0, 1'b1, 1'b1);
    for (int j = 0; j < W - 2; j++) step(1'b0, 1'b0, 1'b1, 1'b1);
    check("R1 one edge early sdo low", link, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    check("R1 single one reaches sdo", link, 1'b1);

    step(1'b0, 1'b1, 1'b1, 1'b0);
    check("R9 transfer and mode change same edge", {drv1, drv0}, 64'hFFFFFFFE_FFFFFFFF);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    check("R4 transparent follow", {drv1, drv0}, 64'h00000002_00000000);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    check("R4 hold after follow", {drv1, drv0}, 64'h00000002_00000000);

    summary();
  end

endmodule